// File: doc/BRIEF.md
# Host Push-Window Output Queue

This block buffers 32-bit words that a host writes toward a downstream port. The host sees a small register space. A range of eight consecutive word addresses works as a push window: a write to any address in that range appends the written word to an 8-entry queue. Because the whole range pushes, a block-move loop over ascending addresses fills the queue without rewinding its pointer. Three further registers hold the control settings, a read-only status word and a set of write-one-to-clear event bits.

The downstream side takes words with a valid/ready handshake, in bursts. A 2-bit control field limits each burst to one, two or three words, or lets a burst run until the queue is empty. A burst also ends early when it takes the only word left. One idle cycle always separates two bursts. When the queue runs dry, a "drained" event latches. That event drives the interrupt output while its enable bit is set. A host write that arrives while the queue is full is discarded, and a sticky overflow event records it.

Top module: `pushwin_fifo`

## Requirements
- R1: After reset, status reads 0x208 (free count 8, empty set), the event register reads 0, and `out_valid_o` and `irq_o` are low.
- R2: A host write to any word address 8 through 15 appends the write data. Words leave on `out_data_o` in the order they were written.
- R3: Status word address 1 holds the number of free slots in bits 3:0 (8 minus occupancy). Bit 8 is set at 8 entries, bit 9 at 0 entries and bit 10 at exactly 1 entry.
- R4: A window write while the queue holds 8 entries is discarded, even if a word is popped in the same cycle, and sets event bit 1 (overflow). That bit stays set until it is cleared.
- R5: Control word address 0, bits 1:0, set the burst cap: 00 allows one word per burst, 01 two and 10 three. `out_last_o` marks the final word of a burst, and `out_valid_o` is low in the cycle after that word is taken.
- R6: With burst cap 11, one burst carries every word that is queued at its start, until the queue is empty.
- R7: A burst that takes the only remaining word marks it with `out_last_o`, whatever the cap. `out_valid_o` is never high while the queue is empty.
- R8: Event bit 0 (drained) sets when occupancy goes from non-zero to zero. It does not set at reset, and it does not set again while the queue stays empty.
- R9: Writing the event register (address 2) with a 1 in a bit clears that bit. A 0 leaves the bit as it is. If a new event arrives in the same cycle as its clear, the event wins.
- R10: `irq_o` is high exactly while event bit 0 is set and the control enable bit 4 is set.
- R11: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 4 | Host write word address |
| host_wdata_i | input | 32 | Host write data |
| host_raddr_i | input | 4 | Host read word address |
| host_rdata_o | output | 32 | Host read data (combinational) |
| out_valid_o | output | 1 | Downstream word valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 32 | Downstream word |
| out_last_o | output | 1 | Final word of the current burst |
| irq_o | output | 1 | Drained interrupt |

## Verification
The embedded properties check the cycle-level rules on every cycle. Valid is held under backpressure, and the data does not change while it waits. An idle cycle follows every last beat, and valid is never raised on an empty queue. An accepted push raises the occupancy by exactly one, net of a pop in the same cycle. The drained event rises only after an empty cycle, and overflow stays set until it is cleared. Other behaviours need whole scenarios, which only the bench provides. These are the per-cap burst lengths and the drain-until-empty mode, the order of words written across different window addresses, the status encodings at 0, 1 and 8 entries, the interrupt gating, and the effect of write-one-to-clear against write-zero.

// File: rtl/pushwin_pkg.sv
package pushwin_pkg;

    typedef enum logic [1:0] {
        CAP_ONE   = 2'b00,
        CAP_TWO   = 2'b01,
        CAP_THREE = 2'b10,
        CAP_ALL   = 2'b11
    } cap_e;

    localparam int CTRL_OFS  = 0;
    localparam int STAT_OFS  = 1;
    localparam int EVT_OFS   = 2;

    localparam int CTRL_IEN_BIT  = 4;
    localparam int STAT_FULL_BIT = 8;
    localparam int STAT_EMPT_BIT = 9;
    localparam int STAT_ONE_BIT  = 10;

    localparam int EVT_DRAIN_BIT = 0;
    localparam int EVT_OVF_BIT   = 1;
    localparam int EVT_W         = 2;

endpackage

// File: rtl/pushwin_store.sv
module pushwin_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic              accept_o,
    output logic [DATA_W-1:0] head_o,
    output logic [CNT_W-1:0]  count_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } store_t;

    store_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic acc;

    always_comb begin
        st_d = st_q;
        acc  = push_i && (st_q.cnt != FULL_CNT);
        if (acc) begin
            st_d.wr = (st_q.wr == LAST_PTR) ? '0 : st_q.wr + 1'b1;
        end
        if (pop_i) begin
            st_d.rd = (st_q.rd == LAST_PTR) ? '0 : st_q.rd + 1'b1;
        end
        st_d.cnt = st_q.cnt + (acc ? CNT_W'(1) : CNT_W'(0))
                            - (pop_i ? CNT_W'(1) : CNT_W'(0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (acc) begin
            mem_q[st_q.wr] <= push_data_i;
        end
    end

    assign accept_o = acc;
    assign head_o   = mem_q[st_q.rd];
    assign count_o  = st_q.cnt;

    assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (st_q.cnt != '0));

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == FULL_CNT) && push_i && !pop_i |=> (st_q.cnt == FULL_CNT));

endmodule

// File: rtl/pushwin_burst.sv
module pushwin_burst #(
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  pushwin_pkg::cap_e  cap_i,
    input  logic [CNT_W-1:0]   count_i,
    input  logic               ready_i,
    output logic               valid_o,
    output logic               last_o,
    output logic               pop_o
);
    import pushwin_pkg::*;

    typedef struct packed {
        logic       active;
        logic [1:0] beat;
    } burst_t;

    burst_t bs_d, bs_q;
    logic   last;
    logic   pop;

    always_comb begin
        bs_d = bs_q;
        last = bs_q.active &&
               ((count_i == CNT_W'(1)) ||
                ((cap_i != CAP_ALL) && (bs_q.beat == 2'(cap_i))));
        pop  = bs_q.active && ready_i;
        if (!bs_q.active) begin
            bs_d.beat = '0;
            if (count_i != '0) begin
                bs_d.active = 1'b1;
            end
        end else if (pop) begin
            if (last) begin
                bs_d.active = 1'b0;
            end else begin
                bs_d.beat = bs_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bs_q <= '0;
        end else begin
            bs_q <= bs_d;
        end
    end

    assign valid_o = bs_q.active;
    assign last_o  = last;
    assign pop_o   = pop;

    assert_gap_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && ready_i && last_o |=> !valid_o);

    assert_no_valid_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (count_i != '0));

    assert_valid_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i |=> valid_o);

endmodule

// File: rtl/pushwin_irq.sv
module pushwin_irq #(
    parameter int EVT_W = pushwin_pkg::EVT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             empty_i,
    input  logic             ovf_i,
    input  logic [EVT_W-1:0] clr_i,
    input  logic             en_i,
    output logic [EVT_W-1:0] evt_o,
    output logic             irq_o
);
    import pushwin_pkg::*;

    typedef struct packed {
        logic             was_empty;
        logic [EVT_W-1:0] evt;
    } irq_t;

    irq_t ir_d, ir_q;
    logic [EVT_W-1:0] set_v;

    always_comb begin
        set_v = '0;
        set_v[EVT_DRAIN_BIT] = empty_i && !ir_q.was_empty;
        set_v[EVT_OVF_BIT]   = ovf_i;
        ir_d.was_empty = empty_i;
        ir_d.evt       = (ir_q.evt & ~clr_i) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q.was_empty <= 1'b1;
            ir_q.evt       <= '0;
        end else begin
            ir_q <= ir_d;
        end
    end

    assign evt_o = ir_q.evt;
    assign irq_o = ir_q.evt[EVT_DRAIN_BIT] && en_i;

    assert_drain_after_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_o[EVT_DRAIN_BIT]) |-> $past(empty_i));

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o[EVT_OVF_BIT] && !clr_i[EVT_OVF_BIT] |=> evt_o[EVT_OVF_BIT]);

endmodule

// File: rtl/pushwin_fifo.sv
module pushwin_fifo #(
    parameter int DATA_W    = 32,
    parameter int DEPTH     = 8,
    parameter int ADDR_W    = 4,
    parameter int WIN_BASE  = 8,
    parameter int WIN_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    input  logic [ADDR_W-1:0] host_raddr_i,
    output logic [DATA_W-1:0] host_rdata_o,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [DATA_W-1:0] out_data_o,
    output logic              out_last_o,
    output logic              irq_o
);
    import pushwin_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [ADDR_W-1:0] WIN_LO   = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] WIN_HI   = ADDR_W'(WIN_BASE + WIN_WORDS - 1);
    localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic irq_en;
        cap_e cap;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic             win_hit;
    logic             accept;
    logic             pop;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] free_cnt;
    logic             full;
    logic             empty;
    logic             one_left;
    logic [EVT_W-1:0] evt;
    logic [EVT_W-1:0] evt_clr;

    assign win_hit  = host_wr_i && (host_addr_i >= WIN_LO) && (host_addr_i <= WIN_HI);
    assign full     = (count == FULL_CNT);
    assign empty    = (count == '0);
    assign one_left = (count == CNT_W'(1));
    assign free_cnt = FULL_CNT - count;
    assign evt_clr  = (host_wr_i && (host_addr_i == ADDR_W'(EVT_OFS)))
                      ? host_wdata_i[EVT_W-1:0] : '0;

    always_comb begin
        ctl_d = ctl_q;
        if (host_wr_i && (host_addr_i == ADDR_W'(CTRL_OFS))) begin
            ctl_d.cap    = cap_e'(host_wdata_i[1:0]);
            ctl_d.irq_en = host_wdata_i[CTRL_IEN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{irq_en: 1'b0, cap: CAP_ONE};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        host_rdata_o = '0;
        case (host_raddr_i)
            ADDR_W'(CTRL_OFS): begin
                host_rdata_o[1:0]          = ctl_q.cap;
                host_rdata_o[CTRL_IEN_BIT] = ctl_q.irq_en;
            end
            ADDR_W'(STAT_OFS): begin
                host_rdata_o[CNT_W-1:0]     = free_cnt;
                host_rdata_o[STAT_FULL_BIT] = full;
                host_rdata_o[STAT_EMPT_BIT] = empty;
                host_rdata_o[STAT_ONE_BIT]  = one_left;
            end
            ADDR_W'(EVT_OFS): begin
                host_rdata_o[EVT_W-1:0] = evt;
            end
            default: host_rdata_o = '0;
        endcase
    end

    pushwin_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (win_hit),
        .push_data_i(host_wdata_i),
        .pop_i      (pop),
        .accept_o   (accept),
        .head_o     (out_data_o),
        .count_o    (count)
    );

    pushwin_burst #(.DEPTH(DEPTH)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (ctl_q.cap),
        .count_i (count),
        .ready_i (out_ready_i),
        .valid_o (out_valid_o),
        .last_o  (out_last_o),
        .pop_o   (pop)
    );

    pushwin_irq #(.EVT_W(EVT_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .empty_i (empty),
        .ovf_i   (win_hit && !accept),
        .clr_i   (evt_clr),
        .en_i    (ctl_q.irq_en),
        .evt_o   (evt),
        .irq_o   (irq_o)
    );

    assert_push_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit && !full |=>
        (count == $past(count) + CNT_W'(1) - ($past(pop) ? CNT_W'(1) : CNT_W'(0))));

    assert_data_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> $stable(out_data_o));

endmodule

// File: tb/pushwin_fifo_bench.sv
module pushwin_fifo_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [3:0]  host_raddr = '0;
    logic [31:0] host_rdata;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        out_last;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cap_words = 1;
    int beat_n = 0;
    bit gap_pend = 0;
    bit finished = 0;
    logic [31:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pushwin_fifo u_pushwin_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr_i   (host_wr),
        .host_addr_i (host_addr),
        .host_wdata_i(host_wdata),
        .host_raddr_i(host_raddr),
        .host_rdata_o(host_rdata),
        .out_valid_o (out_valid),
        .out_ready_i (out_ready),
        .out_data_o  (out_data),
        .out_last_o  (out_last),
        .irq_o       (irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic host_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // Driver: pushes through the window and records the expectation.
    task automatic push_word(input logic [3:0] a, input logic [31:0] d);
        if (exp_q.size() < DEPTH) exp_q.push_back(d);
        host_write(a, d);
    endtask

    task automatic read_reg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        host_raddr = a;
        #1 d = host_rdata;
    endtask

    task automatic set_ctrl(input int cap, input bit ien);
        host_write(4'd0, 32'(cap) | (ien ? 32'h10 : 32'h0));
        cap_words = (cap == 3) ? 1000 : cap + 1;
    endtask

    task automatic drain(input int cyc);
        @(negedge clk); out_ready = 1'b1;
        repeat (cyc) @(negedge clk);
        out_ready = 1'b0;
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R6", "all queued words delivered",
            32'(exp_q.size()), 32'd0);
    endtask

    // Monitor: compares each taken word and the burst shape.
    always begin
        @(negedge clk); #2;
        if (rst_n) begin
            if (gap_pend) begin
                chk(!out_valid, "R5", "idle cycle after last beat", 32'(out_valid), 32'd0);
                gap_pend = 0;
            end else if (out_valid && out_ready) begin
                logic [31:0] e;
                bit exp_last;
                if (exp_q.size() == 0) begin
                    chk(0, "R7", "word delivered from empty model", out_data, 32'hx);
                end else begin
                    e = exp_q.pop_front();
                    chk(out_data == e, "R2", "word order", out_data, e);
                    beat_n++;
                    chk(beat_n <= cap_words, "R5", "burst length within cap",
                        32'(beat_n), 32'(cap_words));
                    exp_last = (beat_n == cap_words) || (exp_q.size() == 0);
                    chk(out_last == exp_last, "R7", "last-beat marker",
                        32'(out_last), 32'(exp_last));
                    if (out_last) begin
                        beat_n = 0;
                        gap_pend = 1;
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_reg(4'd1, r); chk(r == 32'h208, "R1", "status after reset", r, 32'h208);
        read_reg(4'd2, r); chk(r == 32'h0, "R1", "events after reset", r, 32'h0);
        chk(!out_valid && !irq, "R1", "valid/irq low after reset",
            {30'd0, out_valid, irq}, 32'd0);
        repeat (4) @(negedge clk);
        read_reg(4'd2, r); chk(r == 32'h0, "R8", "no drained event while empty from reset", r, 32'h0);

        // R2/R3/R5: cap one word, pushes across window addresses
        set_ctrl(0, 1'b0);
        push_word(4'd8,  32'hA000_0001);
        push_word(4'd11, 32'hA000_0002);
        push_word(4'd15, 32'hA000_0003);
        read_reg(4'd1, r); chk(r == 32'h005, "R3", "status with 3 entries", r, 32'h005);
        drain(20);

        // R8/R9/R10
        read_reg(4'd2, r); chk(r == 32'h1, "R8", "drained event set", r, 32'h1);
        chk(!irq, "R10", "irq masked while disabled", 32'(irq), 32'd0);
        host_write(4'd2, 32'h0);
        read_reg(4'd2, r); chk(r == 32'h1, "R9", "write 0 keeps event", r, 32'h1);
        host_write(4'd2, 32'h1);
        read_reg(4'd2, r); chk(r == 32'h0, "R9", "write 1 clears event", r, 32'h0);
        repeat (5) @(negedge clk);
        read_reg(4'd2, r); chk(r == 32'h0, "R8", "no re-fire while empty", r, 32'h0);

        set_ctrl(0, 1'b1);
        push_word(4'd9, 32'hB000_0001);
        read_reg(4'd1, r); chk(r == 32'h407, "R3", "almost-empty with 1 entry", r, 32'h407);
        chk(!irq, "R10", "irq low before drain", 32'(irq), 32'd0);
        drain(10);
        chk(irq, "R10", "irq high after drain with enable", 32'(irq), 32'd1);
        host_write(4'd2, 32'h1);
        #1 chk(!irq, "R10", "irq low after clear", 32'(irq), 32'd0);

        // R5 cap two and three
        set_ctrl(1, 1'b0);
        for (int i = 0; i < 5; i++) push_word(4'(8 + i), 32'hC000_0000 + 32'(i));
        drain(30);
        set_ctrl(2, 1'b0);
        for (int i = 0; i < 7; i++) push_word(4'(14 - i), 32'hD000_0000 + 32'(i));
        drain(30);

        // R4/R6: fill, overflow, drain in one burst
        host_write(4'd2, 32'h3);
        set_ctrl(3, 1'b0);
        for (int i = 0; i < 8; i++) push_word(4'(8 + i), 32'hE000_0000 + 32'(i));
        read_reg(4'd1, r); chk(r == 32'h100, "R3", "full status", r, 32'h100);
        read_reg(4'd2, r); chk(r == 32'h0, "R4", "no overflow yet", r, 32'h0);
        push_word(4'd12, 32'hDEAD_BEEF);
        read_reg(4'd2, r); chk(r == 32'h2, "R4", "overflow event set", r, 32'h2);
        read_reg(4'd1, r); chk(r == 32'h100, "R4", "dropped write kept count", r, 32'h100);
        repeat (3) @(negedge clk);
        read_reg(4'd2, r); chk(r == 32'h2, "R4", "overflow sticky", r, 32'h2);
        drain(20);
        read_reg(4'd2, r); chk(r == 32'h3, "R8", "drained and overflow both set", r, 32'h3);

        // R11 backpressure
        for (int i = 0; i < 4; i++) push_word(4'd10, 32'hF000_0000 + 32'(i));
        for (int i = 0; i < 24; i++) begin
            @(negedge clk); out_ready = (i % 3 == 2);
        end
        drain(10);
        read_reg(4'd1, r); chk(r == 32'h208, "R3", "empty status at end", r, 32'h208);

        finished = 1;
        summary();
        $finish;
    end
endmodule